// File: doc/BRIEF.md
# Host Command Word Decoder

This block sits behind a host link and turns a stream of 64-bit host words into work for four downstream consumers. Each word holds a 32-bit payload in its low half and a 32-bit control field in its high half. The decoder checks a fixed signature byte in the control field and reads a 4-bit kind code from it. It then places the payload on one of four output channels, together with the command identifier and the spare bits. The four channels are packet transmit, configuration access, loopback back to the host, and command.

Words with a wrong signature are dropped and counted, and so are words with an unknown kind code. The spare bits must be zero for every kind except configuration access. If they are not, the word is still delivered, and a one-cycle format-error pulse is raised. One registered output stage holds the word being delivered. Input ready follows the ready of that held word's channel, so a stalled consumer stalls the host stream and no word is lost or doubled.

Top module: `host_cmd_decoder`

## Requirements
- R1: Word layout: bits [31:0] are the payload. In the control half, bits [39:32] are the signature, bits [43:40] the kind code, bits [55:44] the spare field and bits [63:56] the command identifier. At the clock edge that accepts a dispatchable word (in_valid_i and in_ready_o both high), the word's payload, identifier and spare field appear on ch_data_o, ch_id_o and ch_extra_o, and its channel's valid bit rises.
- R2: Kind code 0 drives ch_valid_o[0] (packet), 1 drives [1] (configuration), 2 drives [2] (loopback) and 3 drives [3] (command). At most one bit of ch_valid_o is ever high.
- R3: A word whose signature is not 0x77 is dropped. No channel valid is raised for it, and bad_magic_cnt_o rises by one at the accepting edge.
- R4: A word with signature 0x77 and a kind code from 4 to 15 is dropped. No channel valid is raised for it, and bad_type_cnt_o rises by one at the accepting edge.
- R5: Both error counters saturate at all ones and never decrease until reset.
- R6: A nonzero spare field on kind 0, 2 or 3 makes fmt_err_o high for the one cycle after the accepting edge, and the word is still delivered. A nonzero spare field on kind 1 raises no error.
- R7: While a channel's valid is high and its ready is low, in_ready_o is low and that channel's valid, data, identifier and spare outputs do not change. A held word leaves the stage at the first edge where its channel's ready is high.
- R8: After reset, ch_valid_o is 0, both counters are 0, fmt_err_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Host word valid |
| in_ready_o | output | 1 | Decoder can take a word |
| in_word_i | input | 64 | Host word (payload low, control high) |
| ch_valid_o | output | 4 | Per-channel valid: packet, config, loopback, command |
| ch_ready_i | input | 4 | Per-channel ready |
| ch_data_o | output | 32 | Payload of the held word |
| ch_id_o | output | 8 | Command identifier of the held word |
| ch_extra_o | output | 12 | Spare field of the held word |
| fmt_err_o | output | 1 | Format error pulse |
| bad_magic_cnt_o | output | CNT_W | Saturating count of signature failures |
| bad_type_cnt_o | output | CNT_W | Saturating count of unknown kind codes |

## Verification
Every result is registered once. The channel outputs, both counters and the format pulse all change at the same edge that accepts the word, so each is due one edge after the stimulus is applied. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. The format pulse is sampled again one cycle later to confirm that it has cleared. In the stall scenario in_ready_o is read between edges, after the drive, and the held outputs are compared over several stalled edges before ready is released.

// File: rtl/host_cmd_pkg.sv
package host_cmd_pkg;
  localparam int unsigned PAY_W   = 32;
  localparam int unsigned ID_W    = 8;
  localparam int unsigned SPARE_W = 12;
  localparam int unsigned KIND_W  = 4;
  localparam int unsigned SIG_W   = 8;
  localparam int unsigned N_CH    = 4;
  localparam logic [SIG_W-1:0] SIG_VAL = 8'h77;

  typedef enum logic [KIND_W-1:0] {
    K_PKT  = 4'd0,
    K_CFG  = 4'd1,
    K_LOOP = 4'd2,
    K_CMD  = 4'd3
  } kind_e;

  // packed msb-first: id, spare, kind, signature
  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic [SPARE_W-1:0] spare;
    logic [KIND_W-1:0]  kind;
    logic [SIG_W-1:0]   sig;
  } ctl_t;

  typedef struct packed {
    ctl_t             ctl;
    logic [PAY_W-1:0] pay;
  } host_word_t;
endpackage

// File: rtl/hcd_field_split.sv
module hcd_field_split
  import host_cmd_pkg::*;
(
  input  host_word_t        word_i,
  output logic              sig_ok_o,
  output logic              kind_known_o,
  output logic [N_CH-1:0]   chan_sel_o,
  output logic              spare_err_o
);
  assign sig_ok_o     = (word_i.ctl.sig == SIG_VAL);
  assign kind_known_o = (word_i.ctl.kind < KIND_W'(N_CH));

  for (genvar g = 0; g < N_CH; g++) begin : g_sel
    assign chan_sel_o[g] = (word_i.ctl.kind == KIND_W'(g));
  end

  // config access uses the spare bits as extra address/data
  assign spare_err_o = (|word_i.ctl.spare) && kind_known_o &&
                       (word_i.ctl.kind != K_CFG);
endmodule

// File: rtl/hcd_sat_counter.sv
module hcd_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_o <= '0;
    else if (inc_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/hcd_out_stage.sv
module hcd_out_stage
  import host_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [N_CH-1:0]    sel_i,
  input  logic [PAY_W-1:0]   pay_i,
  input  logic [ID_W-1:0]    id_i,
  input  logic [SPARE_W-1:0] spare_i,
  input  logic [N_CH-1:0]    ready_i,
  output logic [N_CH-1:0]    valid_o,
  output logic [PAY_W-1:0]   pay_o,
  output logic [ID_W-1:0]    id_o,
  output logic [SPARE_W-1:0] spare_o,
  output logic               free_o
);
  logic drain;
  assign drain  = |(valid_o & ready_i);
  assign free_o = !(|valid_o) || drain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_o <= '0;
    else if (load_i) valid_o <= sel_i;
    else if (drain)  valid_o <= '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_o   <= '0;
      id_o    <= '0;
      spare_o <= '0;
    end else if (load_i) begin
      pay_o   <= pay_i;
      id_o    <= id_i;
      spare_o <= spare_i;
    end
  end
endmodule

// File: rtl/host_cmd_decoder.sv
module host_cmd_decoder
  import host_cmd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [63:0]        in_word_i,
  output logic [N_CH-1:0]    ch_valid_o,
  input  logic [N_CH-1:0]    ch_ready_i,
  output logic [PAY_W-1:0]   ch_data_o,
  output logic [ID_W-1:0]    ch_id_o,
  output logic [SPARE_W-1:0] ch_extra_o,
  output logic               fmt_err_o,
  output logic [CNT_W-1:0]   bad_magic_cnt_o,
  output logic [CNT_W-1:0]   bad_type_cnt_o
);
  host_word_t         word;
  logic               sig_ok, kind_known, spare_err;
  logic [N_CH-1:0]    chan_sel;
  logic               accept, dispatch;

  assign word = host_word_t'(in_word_i);

  hcd_field_split u_split (
    .word_i       (word),
    .sig_ok_o     (sig_ok),
    .kind_known_o (kind_known),
    .chan_sel_o   (chan_sel),
    .spare_err_o  (spare_err)
  );

  assign accept   = in_valid_i && in_ready_o;
  assign dispatch = accept && sig_ok && kind_known;

  hcd_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dispatch),
    .sel_i   (chan_sel),
    .pay_i   (word.pay),
    .id_i    (word.ctl.id),
    .spare_i (word.ctl.spare),
    .ready_i (ch_ready_i),
    .valid_o (ch_valid_o),
    .pay_o   (ch_data_o),
    .id_o    (ch_id_o),
    .spare_o (ch_extra_o),
    .free_o  (in_ready_o)
  );

  hcd_sat_counter #(.W(CNT_W)) u_cnt_sig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept && !sig_ok),
    .cnt_o  (bad_magic_cnt_o)
  );

  hcd_sat_counter #(.W(CNT_W)) u_cnt_kind (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (accept && sig_ok && !kind_known),
    .cnt_o  (bad_type_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fmt_err_o <= 1'b0;
    else         fmt_err_o <= dispatch && spare_err;
  end
endmodule

// File: rtl/host_cmd_decoder_chk.sv
module host_cmd_decoder_chk
  import host_cmd_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_o,
  input logic [63:0]        in_word_i,
  input logic [N_CH-1:0]    ch_valid_o,
  input logic [N_CH-1:0]    ch_ready_i,
  input logic [PAY_W-1:0]   ch_data_o,
  input logic [ID_W-1:0]    ch_id_o,
  input logic [SPARE_W-1:0] ch_extra_o,
  input logic               fmt_err_o,
  input logic [CNT_W-1:0]   bad_magic_cnt_o,
  input logic [CNT_W-1:0]   bad_type_cnt_o
);
  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_valid_o));

  assert_stall_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ch_valid_o & ~ch_ready_i)) |-> !in_ready_o);

  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ch_valid_o & ~ch_ready_i)) |=>
      ($stable(ch_valid_o) && $stable(ch_data_o) && $stable(ch_id_o) && $stable(ch_extra_o)));

  assert_bad_sig_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_word_i[39:32] != 8'h77) |=>
      (ch_valid_o == '0 && (bad_magic_cnt_o != $past(bad_magic_cnt_o) || &bad_magic_cnt_o)));

  assert_cnt_mono_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (bad_magic_cnt_o >= $past(bad_magic_cnt_o) && bad_type_cnt_o >= $past(bad_type_cnt_o)));

  assert_fmt_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && in_word_i[39:32] == 8'h77 && in_word_i[43:40] == 4'd1) |=> !fmt_err_o);
endmodule

bind host_cmd_decoder host_cmd_decoder_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_host_cmd_decoder.sv
`timescale 1ns/1ps
module tb_host_cmd_decoder;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic [3:0]  ch_valid;
  logic [3:0]  ch_ready = 4'hF;
  logic [31:0] ch_data;
  logic [7:0]  ch_id;
  logic [11:0] ch_extra;
  logic        fmt_err;
  logic [CW-1:0] bm_cnt, bt_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  host_cmd_decoder #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_word_i(in_word), .ch_valid_o(ch_valid), .ch_ready_i(ch_ready),
    .ch_data_o(ch_data), .ch_id_o(ch_id), .ch_extra_o(ch_extra),
    .fmt_err_o(fmt_err), .bad_magic_cnt_o(bm_cnt), .bad_type_cnt_o(bt_cnt)
  );

  function automatic logic [63:0] mk(input logic [31:0] pay, input logic [7:0] id,
                                     input logic [11:0] sp, input logic [3:0] kind,
                                     input logic [7:0] sig);
    return {id, sp, kind, sig, pay};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    chk(ch_valid == 4'h0, "R8 valid", ch_valid, 0);
    chk(bm_cnt == 0 && bt_cnt == 0, "R8 counters", {bm_cnt, bt_cnt}, 0);
    chk(fmt_err == 1'b0, "R8 fmt_err", fmt_err, 0);
    chk(in_ready == 1'b1, "R8 in_ready", in_ready, 1);
  endtask

  task automatic t_loopback;
    send(mk(32'h33333333, 8'h00, 12'h000, 4'd2, 8'h77));
    chk(ch_valid == 4'b0100, "R2 loopback channel", ch_valid, 4'b0100);
    chk(ch_data == 32'h33333333, "R1 loopback payload", ch_data, 32'h33333333);
    chk(fmt_err == 1'b0, "R6 no error clean loopback", fmt_err, 0);
    idle(1);
    chk(ch_valid == 4'h0, "R7 drained", ch_valid, 0);
  endtask

  task automatic t_kinds;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] p;
      p = 32'hA5000000 | k;
      send(mk(p, 8'(8'h10 + k), 12'h000, 4'(k), 8'h77));
      chk(ch_valid == 4'(1 << k), "R2 kind select", ch_valid, 4'(1 << k));
      chk(ch_data == p && ch_id == 8'(8'h10 + k), "R1 payload and id", {ch_id, ch_data}, {8'(8'h10 + k), p});
    end
    idle(1);
  endtask

  task automatic t_cfg_extra;
    send(mk(32'hDEADBEEF, 8'hC3, 12'hABC, 4'd1, 8'h77));
    chk(ch_valid == 4'b0010, "R2 cfg channel", ch_valid, 4'b0010);
    chk(ch_extra == 12'hABC && ch_id == 8'hC3, "R1 cfg extra fields", {ch_id, ch_extra}, {8'hC3, 12'hABC});
    chk(fmt_err == 1'b0, "R6 cfg spare allowed", fmt_err, 0);
    idle(1);
  endtask

  task automatic t_spare;
    send(mk(32'h12345678, 8'h05, 12'h001, 4'd3, 8'h77));
    chk(fmt_err == 1'b1, "R6 pulse high", fmt_err, 1);
    chk(ch_valid == 4'b1000 && ch_data == 32'h12345678, "R6 still delivered", {ch_valid, ch_data}, {4'b1000, 32'h12345678});
    idle(1);
    chk(fmt_err == 1'b0, "R6 pulse one cycle", fmt_err, 0);
    send(mk(32'h0, 8'h00, 12'h800, 4'd0, 8'h77));
    chk(fmt_err == 1'b1, "R6 packet spare", fmt_err, 1);
    idle(1);
  endtask

  task automatic t_bad_sig;
    logic [CW-1:0] b;
    b = bm_cnt;
    send(mk(32'h33333333, 8'h00, 12'h000, 4'd2, 8'h76));
    chk(ch_valid == 4'h0, "R3 dropped", ch_valid, 0);
    chk(bm_cnt == b + 1'b1, "R3 counted", bm_cnt, b + 1'b1);
    chk(bt_cnt == 0, "R3 kind counter untouched", bt_cnt, 0);
  endtask

  task automatic t_bad_kind;
    logic [CW-1:0] b;
    b = bt_cnt;
    send(mk(32'h1, 8'h00, 12'h000, 4'd9, 8'h77));
    chk(ch_valid == 4'h0, "R4 dropped", ch_valid, 0);
    chk(bt_cnt == b + 1'b1, "R4 counted", bt_cnt, b + 1'b1);
    send(mk(32'h1, 8'h00, 12'h000, 4'd15, 8'h77));
    chk(bt_cnt == b + 2'd2, "R4 kind 15", bt_cnt, b + 2'd2);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) send(mk(32'h0, 8'h0, 12'h0, 4'd0, 8'h00));
    chk(bm_cnt == {CW{1'b1}}, "R5 saturated", bm_cnt, {CW{1'b1}});
    send(mk(32'h0, 8'h0, 12'h0, 4'd0, 8'hFF));
    chk(bm_cnt == {CW{1'b1}}, "R5 stays saturated", bm_cnt, {CW{1'b1}});
  endtask

  task automatic t_stall;
    idle(1);
    ch_ready = 4'b0111;
    send(mk(32'hAAAA0001, 8'h21, 12'h000, 4'd3, 8'h77));
    chk(ch_valid == 4'b1000, "R7 held word", ch_valid, 4'b1000);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = mk(32'hBBBB0002, 8'h00, 12'h000, 4'd2, 8'h77);
    #1;
    chk(in_ready == 1'b0, "R7 ready low while stalled", in_ready, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(ch_valid == 4'b1000 && ch_data == 32'hAAAA0001 && ch_id == 8'h21, "R7 held stable",
        {ch_valid, ch_data}, {4'b1000, 32'hAAAA0001});
    @(negedge clk);
    ch_ready = 4'hF;
    #1;
    chk(in_ready == 1'b1, "R7 ready follows channel", in_ready, 1);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(ch_valid == 4'b0100 && ch_data == 32'hBBBB0002, "R7 next word after release",
        {ch_valid, ch_data}, {4'b0100, 32'hBBBB0002});
    idle(1);
    chk(ch_valid == 4'h0, "R7 delivered once", ch_valid, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_loopback;
    t_kinds;
    t_cfg_extra;
    t_spare;
    t_bad_sig;
    t_bad_kind;
    t_stall;
    t_saturate;
    finish_run;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run;
  end
endmodule